// File: doc/BRIEF.md
# Mode-Banked Multiport Register File

This block is the architectural register store of a processor core that keeps several operating modes. Software names sixteen registers with a 4-bit index. Inside the block each index is translated to one entry of a larger physical array, and the translation depends on the operating mode presented on the `mode` input. The low registers and the top register exist once and every mode sees the same copy. The upper-middle registers are banked: some modes reach private copies through the same index.

The block has two combinational read ports and one synchronous write port, each with its own address. The mode input applies to all three ports in the same cycle. Reads return the contents of the mapped entry at once. A write updates the entry that is mapped under the mode present at the rising clock edge. A synchronous reset clears every physical entry. Mode-change sequencing, exception entry and program-counter behaviour stay outside the block.

Top module: `banked_regfile`

## Requirements
- R1: The 3-bit mode input is encoded as 0 user, 1 system, 2 fast-interrupt, 3 interrupt, 4 supervisor, 5 abort, 6 undefined; code 7 maps exactly as user. Indices 0 to 7 select one shared entry each, identical in every mode.
- R2: Indices 8 to 12 select a set of five entries shared by every mode except fast-interrupt (code 2), which has its own five private entries for those indices.
- R3: Indices 13 and 14 select a private pair per mode group: user, system and code 7 share one pair, and each of codes 2, 3, 4, 5 and 6 has a pair of its own.
- R4: Index 15 selects a single entry shared by every mode.
- R5: When `wen` is high at a rising clock edge, `wdata` is stored in the entry that `waddr` maps to under the mode at that edge. When `wen` is low, no entry changes.
- R6: Both read ports are combinational and independent. A read of the entry being written in the same cycle returns the value held before that edge.
- R7: When `rst` is high at a rising edge, every physical entry becomes zero, and a write requested in that cycle is discarded.
- R8: Each index under a given mode maps to exactly one entry. A write becomes visible through every (mode, index) pair that maps to the same entry, and through no other pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, clears all entries |
| mode | input | 3 | Current operating mode code |
| raddr_a | input | 4 | Register index for read port A |
| raddr_b | input | 4 | Register index for read port B |
| waddr | input | 4 | Register index for the write port |
| wen | input | 1 | Write enable |
| wdata | input | DW | Write data |
| rdata_a | output | DW | Read data of port A |
| rdata_b | output | DW | Read data of port B |

## Verification
Read data is due in the same cycle as its address and mode, so the bench drives inputs on the falling edge and compares both read ports a short settling delay later, before the next rising edge. Because of that ordering, a read of the entry being written in that cycle is compared against the old value. A write or a reset takes effect at the next rising edge. The bench updates its reference array at that edge, so every later read is compared with the new contents. Directed sequences cross modes between write and read to expose the banking, and several thousand random cycles with every mode code then check each read against the reference.

// File: rtl/bregf_pkg.sv
package bregf_pkg;

   typedef enum logic [2:0] {
      MODE_USR = 3'd0,
      MODE_SYS = 3'd1,
      MODE_FIQ = 3'd2,
      MODE_IRQ = 3'd3,
      MODE_SVC = 3'd4,
      MODE_ABT = 3'd5,
      MODE_UND = 3'd6,
      MODE_RSV = 3'd7
   } cpu_mode_e;

   localparam int IDX_W      = 4;
   localparam int ARCH_REGS  = 1 << IDX_W;
   localparam int LOW_CNT    = 8;
   localparam int MID_LO     = LOW_CNT;
   localparam int MID_CNT    = 5;
   localparam int PRIV_LO    = MID_LO + MID_CNT;
   localparam int PRIV_CNT   = 2;
   localparam int PRIV_BANKS = 6;
   localparam int TOP_IDX    = ARCH_REGS - 1;

   localparam int BASE_MID   = LOW_CNT;
   localparam int FAST_MID   = BASE_MID + MID_CNT;
   localparam int PRIV_BASE  = FAST_MID + MID_CNT;
   localparam int TOP_SLOT   = PRIV_BASE + PRIV_BANKS * PRIV_CNT;
   localparam int PHYS_REGS  = TOP_SLOT + 1;
   localparam int PHYS_W     = $clog2(PHYS_REGS);
   localparam int BANK_W     = $clog2(PRIV_BANKS);

   function automatic logic [BANK_W-1:0] priv_bank(input cpu_mode_e m);
      logic [BANK_W-1:0] b;
      case (m)
         MODE_FIQ: b = BANK_W'(1);
         MODE_IRQ: b = BANK_W'(2);
         MODE_SVC: b = BANK_W'(3);
         MODE_ABT: b = BANK_W'(4);
         MODE_UND: b = BANK_W'(5);
         default:  b = BANK_W'(0);
      endcase
      return b;
   endfunction

endpackage

// File: rtl/bregf_map.sv
module bregf_map
   import bregf_pkg::*;
(
   input  cpu_mode_e         mode,
   input  logic [IDX_W-1:0]  idx,
   output logic [PHYS_W-1:0] phys
);

   logic [BANK_W-1:0] bank;
   int                slot;

   always_comb begin
      bank = priv_bank(mode);
      if (int'(idx) < LOW_CNT) begin
         slot = int'(idx);
      end else if (int'(idx) == TOP_IDX) begin
         slot = TOP_SLOT;
      end else if (int'(idx) < PRIV_LO) begin
         if (mode == MODE_FIQ) slot = FAST_MID + (int'(idx) - MID_LO);
         else                  slot = BASE_MID + (int'(idx) - MID_LO);
      end else begin
         slot = PRIV_BASE + int'(bank) * PRIV_CNT + (int'(idx) - PRIV_LO);
      end
      phys = PHYS_W'(slot);
   end

endmodule

// File: rtl/bregf_array.sv
module bregf_array #(
   parameter int DW    = 32,
   parameter int DEPTH = 31,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] mem_q [DEPTH]
);

   always_ff @(posedge clk) begin
      for (int e = 0; e < DEPTH; e++) begin
         if (rst)
            mem_q[e] <= '0;
         else if (we && (waddr == AW'(e)))
            mem_q[e] <= wdata;
      end
   end

endmodule

// File: rtl/bregf_rdmux.sv
module bregf_rdmux #(
   parameter int DW    = 32,
   parameter int DEPTH = 31,
   parameter int AW    = 5
) (
   input  logic [DW-1:0] mem_q [DEPTH],
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] data
);

   always_comb begin
      data = '0;
      for (int e = 0; e < DEPTH; e++)
         if (addr == AW'(e)) data = mem_q[e];
   end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import bregf_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [2:0]           mode,
   input  logic [IDX_W-1:0]     raddr_a,
   input  logic [IDX_W-1:0]     raddr_b,
   input  logic [IDX_W-1:0]     waddr,
   input  logic                 wen,
   input  logic [DW-1:0]        wdata,
   output logic [DW-1:0]        rdata_a,
   output logic [DW-1:0]        rdata_b
);

   localparam int NUM_RD = 2;

   if (DW < 1) begin : g_bad_dw
      $error("banked_regfile: DW must be at least 1");
   end
   if (PHYS_REGS > (1 << PHYS_W)) begin : g_bad_depth
      $error("banked_regfile: physical index too narrow");
   end

   cpu_mode_e         mode_e;
   logic [PHYS_W-1:0] wphys;
   logic [PHYS_W-1:0] rphys  [NUM_RD];
   logic [IDX_W-1:0]  raddr_v[NUM_RD];
   logic [DW-1:0]     rdata_v[NUM_RD];
   logic [DW-1:0]     mem_q  [PHYS_REGS];

   assign mode_e     = cpu_mode_e'(mode);
   assign raddr_v[0] = raddr_a;
   assign raddr_v[1] = raddr_b;
   assign rdata_a    = rdata_v[0];
   assign rdata_b    = rdata_v[1];

   bregf_map u_wmap (
      .mode (mode_e),
      .idx  (waddr),
      .phys (wphys)
   );

   bregf_array #(.DW(DW), .DEPTH(PHYS_REGS), .AW(PHYS_W)) u_array (
      .clk   (clk),
      .rst   (rst),
      .we    (wen),
      .waddr (wphys),
      .wdata (wdata),
      .mem_q (mem_q)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      bregf_map u_rmap (
         .mode (mode_e),
         .idx  (raddr_v[p]),
         .phys (rphys[p])
      );
      bregf_rdmux #(.DW(DW), .DEPTH(PHYS_REGS), .AW(PHYS_W)) u_mux (
         .mem_q (mem_q),
         .addr  (rphys[p]),
         .data  (rdata_v[p])
      );
   end

endmodule

// File: rtl/bregf_chk.sv
module bregf_chk
   import bregf_pkg::*;
#(
   parameter int DW = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [2:0]        mode,
   input logic [IDX_W-1:0]  raddr_a,
   input logic              wen,
   input logic [DW-1:0]     wdata,
   input logic [DW-1:0]     rdata_a,
   input logic [DW-1:0]     rdata_b,
   input logic [PHYS_W-1:0] wphys,
   input logic [PHYS_W-1:0] rphys_a,
   input logic [DW-1:0]     mem [PHYS_REGS]
);

   // R1
   low_shared_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(raddr_a) < LOW_CNT) |-> (int'(rphys_a) == int'(raddr_a)));

   // R2
   fast_mid_chk: assert property (@(posedge clk) disable iff (rst)
      ((mode == 3'd2) && (int'(raddr_a) >= MID_LO) && (int'(raddr_a) < PRIV_LO))
      |-> ((int'(rphys_a) >= FAST_MID) && (int'(rphys_a) < PRIV_BASE)));

   // R8
   phys_range_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(rphys_a) < PHYS_REGS) && (int'(wphys) < PHYS_REGS));

   // R5
   write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      wen |=> (mem[$past(wphys)] == $past(wdata)));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!wen) && $past(!rst) && $stable(raddr_a) && $stable(mode))
      |-> $stable(rdata_a));

   // R7
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> ((rdata_a == '0) && (rdata_b == '0)));

endmodule

bind banked_regfile bregf_chk #(.DW(DW)) i_chk (
   .clk     (clk),
   .rst     (rst),
   .mode    (mode),
   .raddr_a (raddr_a),
   .wen     (wen),
   .wdata   (wdata),
   .rdata_a (rdata_a),
   .rdata_b (rdata_b),
   .wphys   (wphys),
   .rphys_a (rphys[0]),
   .mem     (mem_q)
);

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [2:0]    mode = '0;
   logic [3:0]    raddr_a = '0, raddr_b = '0, waddr = '0;
   logic          wen = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata_a, rdata_b;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   logic [DW-1:0] model [31];

   always #2 clk = ~clk;

   banked_regfile #(.DW(DW)) i_banked_regfile (
      .clk(clk), .rst(rst), .mode(mode),
      .raddr_a(raddr_a), .raddr_b(raddr_b), .waddr(waddr),
      .wen(wen), .wdata(wdata), .rdata_a(rdata_a), .rdata_b(rdata_b)
   );

   // Reference storage key: one slot per distinct entry the requirements define.
   function automatic int key(input logic [2:0] m, input logic [3:0] i);
      int grp;
      case (m)
         3'd2: grp = 1;
         3'd3: grp = 2;
         3'd4: grp = 3;
         3'd5: grp = 4;
         3'd6: grp = 5;
         default: grp = 0;
      endcase
      if (i == 4'd15)     return 30;
      if (i <= 4'd7)      return int'(i);
      if (i <= 4'd12)     return (m == 3'd2) ? 13 + int'(i) - 8 : int'(i);
      return 18 + grp * 2 + int'(i) - 13;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // One cycle: drive at falling edge, check reads before the rising edge,
   // then apply the write/reset to the reference at that edge.
   task automatic step(input string req, input logic r, input logic [2:0] m,
                       input logic [3:0] ra, input logic [3:0] rb,
                       input logic we, input logic [3:0] wa, input logic [DW-1:0] wd);
      @(negedge clk);
      rst = r; mode = m; raddr_a = ra; raddr_b = rb;
      wen = we; waddr = wa; wdata = wd;
      #1;
      check(req, "port A", rdata_a, model[key(m, ra)]);
      check(req, "port B", rdata_b, model[key(m, rb)]);
      @(posedge clk);
      if (r) begin
         for (int k = 0; k < 31; k++) model[k] = '0;
      end else if (we) begin
         model[key(m, wa)] = wd;
      end
   endtask

   task automatic rd(input string req, input logic [2:0] m, input logic [3:0] ra,
                     input logic [DW-1:0] exp);
      @(negedge clk);
      rst = 1'b0; wen = 1'b0; mode = m; raddr_a = ra; raddr_b = ra;
      #1;
      check(req, "port A const", rdata_a, exp);
      check(req, "port B const", rdata_b, exp);
   endtask

   initial begin
      for (int k = 0; k < 31; k++) model[k] = 'x;
      void'($urandom(32'h5EED_0042));
      // R7: reset state
      @(posedge clk);
      for (int k = 0; k < 31; k++) model[k] = '0;
      @(posedge clk);
      for (int i = 0; i < 16; i++) rd("R7", 3'd0, 4'(i), '0);

      // R1: low index shared across modes
      step("R1", 0, 3'd0, 4'd3, 4'd3, 1, 4'd3, 32'hA0A0_0003);
      rd("R1", 3'd2, 4'd3, 32'hA0A0_0003);
      rd("R1", 3'd6, 4'd3, 32'hA0A0_0003);

      // R2: middle range banked only for fast-interrupt
      step("R2", 0, 3'd0, 4'd10, 4'd10, 1, 4'd10, 32'hB0B0_000A);
      rd("R2", 3'd2, 4'd10, 32'h0);
      rd("R2", 3'd3, 4'd10, 32'hB0B0_000A);
      step("R2", 0, 3'd2, 4'd10, 4'd12, 1, 4'd10, 32'hC0C0_000A);
      rd("R2", 3'd0, 4'd10, 32'hB0B0_000A);
      rd("R2", 3'd2, 4'd10, 32'hC0C0_000A);

      // R3: private 13/14 per mode group, code 7 and system alias user
      step("R3", 0, 3'd4, 4'd13, 4'd14, 1, 4'd13, 32'hD0D0_000D);
      rd("R3", 3'd0, 4'd13, 32'h0);
      rd("R3", 3'd5, 4'd13, 32'h0);
      rd("R3", 3'd4, 4'd13, 32'hD0D0_000D);
      step("R3", 0, 3'd1, 4'd14, 4'd13, 1, 4'd14, 32'hE0E0_000E);
      rd("R3", 3'd0, 4'd14, 32'hE0E0_000E);
      rd("R3", 3'd7, 4'd14, 32'hE0E0_000E);
      rd("R3", 3'd3, 4'd14, 32'h0);

      // R4: index 15 shared
      step("R4", 0, 3'd6, 4'd15, 4'd0, 1, 4'd15, 32'hF0F0_000F);
      rd("R4", 3'd2, 4'd15, 32'hF0F0_000F);

      // R5: write enable low leaves entries unchanged
      step("R5", 0, 3'd0, 4'd3, 4'd10, 0, 4'd3, 32'hDEAD_BEEF);
      rd("R5", 3'd0, 4'd3, 32'hA0A0_0003);

      // R6: same-cycle read of written entry returns old value
      step("R6", 0, 3'd3, 4'd5, 4'd5, 1, 4'd5, 32'h1111_0005);
      rd("R6", 3'd3, 4'd5, 32'h1111_0005);

      // R7: write during reset discarded, everything cleared
      step("R7", 1, 3'd0, 4'd1, 4'd2, 1, 4'd1, 32'h7777_7777);
      rd("R7", 3'd0, 4'd1, 32'h0);
      rd("R7", 3'd2, 4'd10, 32'h0);
      rd("R7", 3'd4, 4'd13, 32'h0);

      // R8: random traffic over all modes against the reference
      for (int n = 0; n < 4000; n++) begin
         step("R8", ($urandom % 200) == 0, 3'($urandom), 4'($urandom),
              4'($urandom), ($urandom % 3) != 0, 4'($urandom), $urandom);
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule